// File: doc/BRIEF.md
# Dual-Port Address Collision Detector

This block sits beside a two-port synchronous memory. It watches the access that each port makes in each clock cycle and tells a port when the data it handled may be wrong. A collision occurs when both ports are enabled, both target the same location, and at least one of them is writing. The flag goes only to the port or ports whose data were affected. A reading port is flagged when the other port writes to its location. Both ports are flagged when both write to it. Two reads of one location are harmless and raise nothing.

Each port supplies an address that has already been resolved by its address counter logic, a read/write select, and a pair of chip enables with opposite polarities. All of these are captured on the rising edge of a single shared clock. The match decision then passes through a fixed delay pipeline. Each port receives one active-low flag, which stays low for exactly one cycle for each colliding access.

Top module: `dpCollisionDetect`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives both flags high (1 = no collision) from the next cycle. They stay high until a collision is sampled after reset is released.
- R2: A port counts as enabled only when its low-active enable is 0 and its high-active enable is 1 at the sampling edge. If either port is not enabled, no flag is raised on either port, even when the addresses match.
- R3: When both ports are enabled and reading (rdWr = 1) with equal addresses, both flags stay high.
- R4: When the left port reads (rdWr = 1) and the right port writes (rdWr = 0) to the same address, only the left flag goes low.
- R5: When the right port reads and the left port writes to the same address, only the right flag goes low.
- R6: When both ports write to the same address, both flags go low.
- R7: When the two sampled addresses differ in any bit, no flag is raised, whatever the enables and read/write selects are.
- R8: For an access sampled at rising edge N, the flag is low from just after edge N+2 until edge N+3. It is still high between edges N+1 and N+2.
- R9: Collisions sampled on consecutive edges give consecutive low cycles on the flag, one per access. The flag returns high one cycle after the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| leftEnLowN | input | 1 | Left port enable, active low |
| leftEnHigh | input | 1 | Left port enable, active high |
| leftRdWr | input | 1 | Left port select: 1 = read, 0 = write |
| leftAddr | input | ADDR_W | Left port resolved internal address |
| rightEnLowN | input | 1 | Right port enable, active low |
| rightEnHigh | input | 1 | Right port enable, active high |
| rightRdWr | input | 1 | Right port select: 1 = read, 0 = write |
| rightAddr | input | ADDR_W | Right port resolved internal address |
| leftColN | output | 1 | Left port collision flag, active low |
| rightColN | output | 1 | Right port collision flag, active low |

## Verification
Each of the four read/write combinations is driven on a matching address. This separates the asymmetric single-port flag cases from the both-write case and from the harmless read-read case. A full sweep covers all enable pin levels on both ports, both selects, and both matching and differing addresses. It shows that only the fully enabled pin pair counts and that a mismatch, including a single differing top bit, suppresses everything. Isolated accesses are checked one cycle before, during and after the expected flag cycle to pin down the latency. Back-to-back collisions followed by a clean access show that each access yields exactly one low cycle.

// File: rtl/dpCollisionPkg.sv
package dpCollisionPkg;

  // Strobes passed from the port control decode to the address datapath.
  typedef struct packed {
    logic bothOn;   // both ports enabled in the captured cycle
    logic leftWr;   // left port captured a write
    logic rightWr;  // right port captured a write
  } portStrobes_t;

  // Index of each port's bit in the flag pipeline vectors.
  localparam int LEFT_BIT  = 1;
  localparam int RIGHT_BIT = 0;

endpackage

// File: rtl/dpCollisionCtrl.sv
module dpCollisionCtrl
  import dpCollisionPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         leftEnLowN,
  input  logic         leftEnHigh,
  input  logic         leftRdWr,
  input  logic         rightEnLowN,
  input  logic         rightEnHigh,
  input  logic         rightRdWr,
  output portStrobes_t strobes
);

  logic leftOn, rightOn;
  logic leftRd, rightRd;

  // Capture stage: resolve the two-pin enable of each port at the edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      leftOn  <= 1'b0;
      rightOn <= 1'b0;
      leftRd  <= 1'b1;
      rightRd <= 1'b1;
    end else begin
      leftOn  <= ~leftEnLowN & leftEnHigh;
      rightOn <= ~rightEnLowN & rightEnHigh;
      leftRd  <= leftRdWr;
      rightRd <= rightRdWr;
    end
  end

  always_comb begin
    strobes.bothOn  = leftOn & rightOn;
    strobes.leftWr  = ~leftRd;
    strobes.rightWr = ~rightRd;
  end

  // R2: both-on may only follow a cycle in which all four enable pins were valid
  assert_enable_pins_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.bothOn |-> ($past(leftEnLowN) == 1'b0 && $past(leftEnHigh) == 1'b1 &&
                        $past(rightEnLowN) == 1'b0 && $past(rightEnHigh) == 1'b1));

  // R2: a port with a bad pin pair never reports as enabled on the next cycle
  assert_disabled_port_R2: assert property (@(posedge clk) disable iff (rst)
    (leftEnLowN || !leftEnHigh || rightEnLowN || !rightEnHigh) |=> !strobes.bothOn);

endmodule

// File: rtl/dpCollisionPath.sv
module dpCollisionPath
  import dpCollisionPkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int PIPE_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic [ADDR_W-1:0] rightAddr,
  input  portStrobes_t      strobes,
  output logic              leftHit,
  output logic              rightHit
);

  localparam int LAST = PIPE_STAGES - 1;

  logic [ADDR_W-1:0] leftAddrQ, rightAddrQ;
  logic              sameAddr;
  logic [1:0]        hitNow;
  logic [1:0]        hitPipe [PIPE_STAGES];

  // Capture stage: addresses registered alongside the control capture.
  always_ff @(posedge clk) begin
    if (rst) begin
      leftAddrQ  <= '0;
      rightAddrQ <= '0;
    end else begin
      leftAddrQ  <= leftAddr;
      rightAddrQ <= rightAddr;
    end
  end

  assign sameAddr = (leftAddrQ == rightAddrQ);

  // A port is hit when the other port wrote the shared location.
  always_comb begin
    hitNow            = 2'b00;
    hitNow[LEFT_BIT]  = strobes.bothOn & sameAddr & strobes.rightWr;
    hitNow[RIGHT_BIT] = strobes.bothOn & sameAddr & strobes.leftWr;
  end

  // Fixed delay chain from decision to flag.
  generate
    for (genvar s = 0; s < PIPE_STAGES; s++) begin : g_pipe
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) hitPipe[0] <= 2'b00;
          else     hitPipe[0] <= hitNow;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) hitPipe[s] <= 2'b00;
          else     hitPipe[s] <= hitPipe[s-1];
        end
        // R8: each stage forwards its contents unchanged
        assert_pipe_shift_R8: assert property (@(posedge clk) disable iff (rst)
          1'b1 |=> (hitPipe[s] == $past(hitPipe[s-1])));
      end
    end
  endgenerate

  assign leftHit  = hitPipe[LAST][LEFT_BIT];
  assign rightHit = hitPipe[LAST][RIGHT_BIT];

  // R3: two reads of one location mark nothing
  assert_read_read_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (strobes.bothOn && sameAddr && !strobes.leftWr && !strobes.rightWr)
      |=> (hitPipe[0] == 2'b00));

  // R4: left reads, right writes: only the left port is marked
  assert_left_only_R4: assert property (@(posedge clk) disable iff (rst)
    (strobes.bothOn && sameAddr && !strobes.leftWr && strobes.rightWr)
      |=> (hitPipe[0] == 2'b10));

  // R5: right reads, left writes: only the right port is marked
  assert_right_only_R5: assert property (@(posedge clk) disable iff (rst)
    (strobes.bothOn && sameAddr && strobes.leftWr && !strobes.rightWr)
      |=> (hitPipe[0] == 2'b01));

  // R6: two writes mark both ports
  assert_both_write_R6: assert property (@(posedge clk) disable iff (rst)
    (strobes.bothOn && sameAddr && strobes.leftWr && strobes.rightWr)
      |=> (hitPipe[0] == 2'b11));

  // R7: differing addresses mark nothing
  assert_mismatch_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (leftAddrQ != rightAddrQ) |=> (hitPipe[0] == 2'b00));

endmodule

// File: rtl/dpCollisionDetect.sv
module dpCollisionDetect
  import dpCollisionPkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int PIPE_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              leftEnLowN,
  input  logic              leftEnHigh,
  input  logic              leftRdWr,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              rightEnLowN,
  input  logic              rightEnHigh,
  input  logic              rightRdWr,
  input  logic [ADDR_W-1:0] rightAddr,
  output logic              leftColN,
  output logic              rightColN
);

  portStrobes_t strobes;
  logic         leftHit, rightHit;

  dpCollisionCtrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .leftEnLowN  (leftEnLowN),
    .leftEnHigh  (leftEnHigh),
    .leftRdWr    (leftRdWr),
    .rightEnLowN (rightEnLowN),
    .rightEnHigh (rightEnHigh),
    .rightRdWr   (rightRdWr),
    .strobes     (strobes)
  );

  dpCollisionPath #(
    .ADDR_W      (ADDR_W),
    .PIPE_STAGES (PIPE_STAGES)
  ) u_path (
    .clk       (clk),
    .rst       (rst),
    .leftAddr  (leftAddr),
    .rightAddr (rightAddr),
    .strobes   (strobes),
    .leftHit   (leftHit),
    .rightHit  (rightHit)
  );

  assign leftColN  = ~leftHit;
  assign rightColN = ~rightHit;

  // R1: reset releases both flags on the following cycle
  assert_reset_flags_high_R1: assert property (@(posedge clk)
    rst |=> (leftColN && rightColN));

endmodule

// File: tb/tb_dpCollisionDetect.sv
module tb_dpCollisionDetect;

  localparam int  ADDR_W = 18;
  localparam time PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rst;
  logic              leftEnLowN, leftEnHigh, leftRdWr;
  logic              rightEnLowN, rightEnHigh, rightRdWr;
  logic [ADDR_W-1:0] leftAddr, rightAddr;
  logic              leftColN, rightColN;

  int testsRun    = 0;
  int testsFailed = 0;

  always #(PERIOD/2) clk = ~clk;

  dpCollisionDetect #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst),
    .leftEnLowN(leftEnLowN), .leftEnHigh(leftEnHigh), .leftRdWr(leftRdWr), .leftAddr(leftAddr),
    .rightEnLowN(rightEnLowN), .rightEnHigh(rightEnHigh), .rightRdWr(rightRdWr), .rightAddr(rightAddr),
    .leftColN(leftColN), .rightColN(rightColN)
  );

  task automatic checkFlags(input string req, input logic expL, input logic expR);
    testsRun++;
    if (leftColN !== expL || rightColN !== expR) begin
      testsFailed++;
      $display("FAIL %s: flags L/R actual %b%b expected %b%b", req, leftColN, rightColN, expL, expR);
    end
  endtask

  // Both ports disabled, harmless values.
  task automatic driveIdle();
    leftEnLowN = 1'b1; leftEnHigh = 1'b0; leftRdWr = 1'b1; leftAddr = '0;
    rightEnLowN = 1'b1; rightEnHigh = 1'b0; rightRdWr = 1'b1; rightAddr = '0;
  endtask

  task automatic driveAccess(input logic lLow, input logic lHigh, input logic lRw, input logic [ADDR_W-1:0] lA,
                             input logic rLow, input logic rHigh, input logic rRw, input logic [ADDR_W-1:0] rA);
    leftEnLowN = lLow; leftEnHigh = lHigh; leftRdWr = lRw; leftAddr = lA;
    rightEnLowN = rLow; rightEnHigh = rHigh; rightRdWr = rRw; rightAddr = rA;
  endtask

  // Expected active-low flags from the requirements.
  function automatic logic [1:0] expectFlags(input logic lLow, input logic lHigh, input logic lRw,
                                             input logic rLow, input logic rHigh, input logic rRw,
                                             input logic same);
    logic on;
    on = !lLow && lHigh && !rLow && rHigh && same;
    return {~(on && !rRw), ~(on && !lRw)};
  endfunction

  // One isolated access driven at a negedge before edge N; flags checked around N+2.
  task automatic singleAccess(input string req,
                              input logic lLow, input logic lHigh, input logic lRw, input logic [ADDR_W-1:0] lA,
                              input logic rLow, input logic rHigh, input logic rRw, input logic [ADDR_W-1:0] rA,
                              input logic expL, input logic expR, input logic fullTiming);
    @(negedge clk);
    driveAccess(lLow, lHigh, lRw, lA, rLow, rHigh, rRw, rA);
    @(negedge clk);   // after edge N
    driveIdle();
    @(negedge clk);   // after edge N+1
    if (fullTiming) checkFlags({req, " R8 early"}, 1'b1, 1'b1);
    @(negedge clk);   // after edge N+2
    checkFlags(req, expL, expR);
    @(negedge clk);   // after edge N+3
    if (fullTiming) checkFlags({req, " R8 single"}, 1'b1, 1'b1);
  endtask

  task automatic testReset();
    @(negedge clk);
    rst = 1'b1;
    driveIdle();
    @(negedge clk);
    checkFlags("R1 in reset", 1'b1, 1'b1);
    // Collision presented while reset is held must leave no trace.
    driveAccess(1'b0, 1'b1, 1'b0, 18'h00055, 1'b0, 1'b1, 1'b0, 18'h00055);
    @(negedge clk);
    driveIdle();
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checkFlags("R1 after release", 1'b1, 1'b1);
  endtask

  task automatic testReadRead();
    singleAccess("R3 read-read", 1'b0, 1'b1, 1'b1, 18'h1234, 1'b0, 1'b1, 1'b1, 18'h1234, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic testLeftReadRightWrite();
    singleAccess("R4 left flagged", 1'b0, 1'b1, 1'b1, 18'h3ABCD, 1'b0, 1'b1, 1'b0, 18'h3ABCD, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic testRightReadLeftWrite();
    singleAccess("R5 right flagged", 1'b0, 1'b1, 1'b0, 18'h00001, 1'b0, 1'b1, 1'b1, 18'h00001, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic testBothWrite();
    singleAccess("R6 both flagged", 1'b0, 1'b1, 1'b0, 18'h3FFFF, 1'b0, 1'b1, 1'b0, 18'h3FFFF, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testMismatch();
    singleAccess("R7 top bit differs", 1'b0, 1'b1, 1'b0, 18'h20000, 1'b0, 1'b1, 1'b0, 18'h00000, 1'b1, 1'b1, 1'b1);
    singleAccess("R7 low bit differs", 1'b0, 1'b1, 1'b0, 18'h00010, 1'b0, 1'b1, 1'b0, 18'h00011, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic testDisabled();
    singleAccess("R2 left low pin high", 1'b1, 1'b1, 1'b0, 18'h777, 1'b0, 1'b1, 1'b0, 18'h777, 1'b1, 1'b1, 1'b1);
    singleAccess("R2 right high pin low", 1'b0, 1'b1, 1'b0, 18'h777, 1'b0, 1'b0, 1'b0, 18'h777, 1'b1, 1'b1, 1'b0);
  endtask

  // Every pin combination on matching and differing addresses.
  task automatic testSweep();
    for (int code = 0; code < 128; code++) begin
      logic lLow, lHigh, lRw, rLow, rHigh, rRw, same;
      logic [1:0] exp;
      {same, lLow, lHigh, lRw, rLow, rHigh, rRw} = code[6:0];
      exp = expectFlags(lLow, lHigh, lRw, rLow, rHigh, rRw, same);
      singleAccess("R2 R7 sweep", lLow, lHigh, lRw, 18'h0A5A5,
                   rLow, rHigh, rRw, same ? 18'h0A5A5 : 18'h0A5A4, exp[1], exp[0], 1'b0);
    end
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    driveAccess(1'b0, 1'b1, 1'b0, 18'h42, 1'b0, 1'b1, 1'b0, 18'h42);   // edge N: both write
    @(negedge clk);
    driveAccess(1'b0, 1'b1, 1'b1, 18'h43, 1'b0, 1'b1, 1'b0, 18'h43);   // edge N+1: left flagged
    @(negedge clk);
    driveAccess(1'b0, 1'b1, 1'b0, 18'h44, 1'b0, 1'b1, 1'b0, 18'h45);   // edge N+2: mismatch
    @(negedge clk);
    driveIdle();
    checkFlags("R9 first of pair", 1'b0, 1'b0);
    @(negedge clk);
    checkFlags("R9 second of pair", 1'b0, 1'b1);
    @(negedge clk);
    checkFlags("R9 released", 1'b1, 1'b1);
  endtask

  initial begin
    #(PERIOD * 100000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rst = 1'b1;
    driveIdle();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    testReset();
    testReadRead();
    testLeftReadRightWrite();
    testRightReadLeftWrite();
    testBothWrite();
    testMismatch();
    testDisabled();
    testBackToBack();
    testSweep();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule